// File: doc/BRIEF.md
# Burst Bus Initiator

This block is the initiating side of a synchronous burst bus whose address and data share one set of lines. A local client gives it a command with a start address, a direction and a word count. The block then opens a transaction by asserting the frame signal. On the following cycle it places the address and a bus command code on the shared lines. After that it runs data phases until the requested number of words has moved or the target ends the burst.

A word crosses the bus only on a rising edge at which the initiator's ready and the target's ready are both asserted, so either side can stretch any data phase. Frame is withdrawn while exactly one word is still outstanding, which tells the target that the next transfer is the last. On a read, the block leaves the shared lines undriven for one cycle before the target starts driving them. The target can end a burst early with its stop line. When a burst ends for either reason, the block reports how many words actually moved.

Frame, initiator ready, target ready and stop are active-low at the pins. Inside the block they are active-high.

Top module: `burstInit`

## Requirements
- R1: `cmdReady` is high only while the block is idle. A command presented with `cmdValid` in an idle cycle is taken on that edge. In the following cycle frame is asserted (`frameN` low) while `adOe` is low.
- R2: In the cycle after the first frame cycle, `adOe` is high, `adOut` carries the start address and `busCmd` carries 4'b0110 for a read or 4'b0111 for a write. `busCmd` is 4'b0000 in every other cycle.
- R3: On a read there is exactly one turnaround cycle between the address cycle and the first data cycle. In that cycle `adOe` is low and initiator ready is deasserted. `adOe` stays low through the read data phases. On a write, data phases follow the address cycle directly and `adOut` carries `wrData` with `adOe` high.
- R4: During data phases, initiator ready (`irdyN` low) follows `locReady`. `wordMoved` is high exactly in data cycles where initiator ready and target ready (`trdyN` low) are both asserted, and `rdData` is `adIn`.
- R5: Frame stays asserted from the frame cycle until a data phase in which exactly one word remains. It is deasserted in that phase and in every later cycle of the burst.
- R6: Stop (`stopN` low) sampled in a data phase ends the burst on that edge, and the block returns to idle. A word counts as moved only if both readies were asserted on that same edge. Stop outside data phases has no effect.
- R7: In the cycle after the ending edge, `doneValid` is high for one cycle. `doneCount` gives the number of words moved, and `doneStopped` is high if stop was sampled on the ending edge.
- R8: A command word count of zero is treated as a count of one.
- R9: During and after reset, the block is idle with `cmdReady` high, `frameN` and `irdyN` high, `adOe` low and `doneValid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all bus signals are sampled on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| cmdValid | input | 1 | Command present |
| cmdReady | output | 1 | Block idle and able to take a command |
| cmdWrite | input | 1 | 1 = write burst, 0 = read burst |
| cmdAddr | input | DW | Start address |
| cmdCount | input | CW | Words to transfer (0 means 1) |
| wrData | input | DW | Write word currently offered by the client |
| locReady | input | 1 | Client able to move a word this cycle |
| wordMoved | output | 1 | A word moves on the coming edge |
| rdData | output | DW | Read word (valid with `wordMoved` on reads) |
| doneValid | output | 1 | One-cycle completion pulse |
| doneCount | output | CW | Words moved in the finished burst |
| doneStopped | output | 1 | Burst ended by target stop |
| frameN | output | 1 | Frame, active low |
| irdyN | output | 1 | Initiator ready, active low |
| trdyN | input | 1 | Target ready, active low |
| stopN | input | 1 | Target stop, active low |
| busCmd | output | 4 | Bus command code during the address cycle |
| adOut | output | DW | Shared address/data lines, driven value |
| adOe | output | 1 | Drive enable for the shared lines |
| adIn | input | DW | Shared address/data lines, sampled value |

## Verification
The bench targets one-word bursts and zero counts. A design that raised frame in the data phase, or treated a zero count as 256 words, would stall in a single-word burst or keep frame high past the last word. It also targets stop with and without target ready on the same edge. An off-by-one there would report one word too many or too few, or leave the burst running. Read turnarounds are compared cycle by cycle, so a design that drove the shared lines while the target takes them, or skipped the dead cycle, is caught. Random wait states on both readies expose a design that moves a word on only one ready.

// File: rtl/burstInitPkg.sv
package burstInitPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FRAME,
    ST_ADDR,
    ST_TURN,
    ST_DATA
  } phase_t;

  // strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture a new command
    logic take;     // one word moves on this edge
    logic finish;   // burst ends on this edge
    logic stopped;  // ending edge saw target stop
  } strobes_t;

  localparam logic [3:0] CMD_READ  = 4'b0110;
  localparam logic [3:0] CMD_WRITE = 4'b0111;

endpackage

// File: rtl/burstInitCtrl.sv
module burstInitCtrl
  import burstInitPkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     cmdValid,
  input  logic     locReady,
  input  logic     trdy,
  input  logic     stop,
  input  logic     lastWord,
  input  logic     isWrite,
  output logic     cmdReady,
  output logic     frame,
  output logic     irdy,
  output logic     adOe,
  output logic     addrPhase,
  output logic     wordMoved,
  output strobes_t strb
);

  phase_t state, stateNext;
  logic   inData;
  logic   endNow;

  assign inData    = (state == ST_DATA);
  assign wordMoved = inData && locReady && trdy;
  assign endNow    = inData && ((wordMoved && lastWord) || stop);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:  if (cmdValid) stateNext = ST_FRAME;
      ST_FRAME: stateNext = ST_ADDR;
      ST_ADDR:  stateNext = isWrite ? ST_DATA : ST_TURN;
      ST_TURN:  stateNext = ST_DATA;
      ST_DATA:  if (endNow) stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    strb.load    = (state == ST_IDLE) && cmdValid;
    strb.take    = wordMoved;
    strb.finish  = endNow;
    strb.stopped = endNow && stop;
  end

  assign cmdReady  = (state == ST_IDLE);
  assign addrPhase = (state == ST_ADDR);
  assign irdy      = inData && locReady;
  assign adOe      = addrPhase || (inData && isWrite);
  assign frame     = (state == ST_FRAME) || addrPhase || (state == ST_TURN)
                     || (inData && !lastWord);

endmodule

// File: rtl/burstInitDpath.sv
module burstInitDpath
  import burstInitPkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
)(
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic          addrPhase,
  input  logic          cmdWrite,
  input  logic [DW-1:0] cmdAddr,
  input  logic [CW-1:0] cmdCount,
  input  logic [DW-1:0] wrData,
  input  logic [DW-1:0] adIn,
  output logic          isWrite,
  output logic          lastWord,
  output logic [DW-1:0] adOut,
  output logic [3:0]    busCmd,
  output logic [DW-1:0] rdData,
  output logic          doneValid,
  output logic [CW-1:0] doneCount,
  output logic          doneStopped
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [DW-1:0] addrReg;
  logic [CW-1:0] remain;
  logic [CW-1:0] moved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isWrite <= 1'b0;
      addrReg <= '0;
      remain  <= '0;
      moved   <= '0;
    end else if (strb.load) begin
      isWrite <= cmdWrite;
      addrReg <= cmdAddr;
      remain  <= (cmdCount == '0) ? ONE : cmdCount;
      moved   <= '0;
    end else if (strb.take) begin
      remain  <= remain - ONE;
      moved   <= moved + ONE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      doneCount   <= '0;
      doneStopped <= 1'b0;
    end else begin
      doneValid <= strb.finish;
      if (strb.finish) begin
        doneCount   <= strb.take ? moved + ONE : moved;
        doneStopped <= strb.stopped;
      end
    end
  end

  assign lastWord = (remain == ONE);
  assign adOut    = addrPhase ? addrReg : wrData;
  assign busCmd   = addrPhase ? (isWrite ? CMD_WRITE : CMD_READ) : 4'b0000;
  assign rdData   = adIn;

endmodule

// File: rtl/burstInit.sv
module burstInit
  import burstInitPkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 8
)(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdValid,
  output logic          cmdReady,
  input  logic          cmdWrite,
  input  logic [DW-1:0] cmdAddr,
  input  logic [CW-1:0] cmdCount,
  input  logic [DW-1:0] wrData,
  input  logic          locReady,
  output logic          wordMoved,
  output logic [DW-1:0] rdData,
  output logic          doneValid,
  output logic [CW-1:0] doneCount,
  output logic          doneStopped,
  output logic          frameN,
  output logic          irdyN,
  input  logic          trdyN,
  input  logic          stopN,
  output logic [3:0]    busCmd,
  output logic [DW-1:0] adOut,
  output logic          adOe,
  input  logic [DW-1:0] adIn
);

  strobes_t strb;
  logic frame, irdy, addrPhase, isWrite, lastWord;

  burstInitCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .locReady(locReady),
    .trdy(~trdyN), .stop(~stopN), .lastWord(lastWord), .isWrite(isWrite),
    .cmdReady(cmdReady), .frame(frame), .irdy(irdy), .adOe(adOe),
    .addrPhase(addrPhase), .wordMoved(wordMoved), .strb(strb)
  );

  burstInitDpath #(.DW(DW), .CW(CW)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .addrPhase(addrPhase),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdCount(cmdCount),
    .wrData(wrData), .adIn(adIn), .isWrite(isWrite), .lastWord(lastWord),
    .adOut(adOut), .busCmd(busCmd), .rdData(rdData), .doneValid(doneValid),
    .doneCount(doneCount), .doneStopped(doneStopped)
  );

  assign frameN = ~frame;
  assign irdyN  = ~irdy;

endmodule

// File: rtl/burstInitChk.sv
module burstInitChk (
  input logic       clk,
  input logic       rstN,
  input logic       cmdValid,
  input logic       cmdReady,
  input logic       frameN,
  input logic       irdyN,
  input logic       trdyN,
  input logic       adOe,
  input logic [3:0] busCmd,
  input logic       wordMoved,
  input logic       doneValid
);

  // R1
  accept_opens_frame_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdReady) |=> (!frameN && !adOe));

  // R3
  read_turnaround_chk: assert property (@(posedge clk) disable iff (!rstN)
    (adOe && busCmd == 4'b0110) |=> (!adOe && irdyN && !frameN));

  // R4
  both_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    wordMoved |-> (!irdyN && !trdyN));

  // R5
  frame_stays_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdReady && frameN) |=> (frameN || cmdReady));

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R7
  done_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> cmdReady);

endmodule

bind burstInit burstInitChk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .frameN(frameN), .irdyN(irdyN), .trdyN(trdyN), .adOe(adOe),
  .busCmd(busCmd), .wordMoved(wordMoved), .doneValid(doneValid)
);

// File: tb/test_burstInit.sv
module test_burstInit;

  localparam int DW = 32;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic cmdWrite = 1'b0;
  logic [DW-1:0] cmdAddr = '0;
  logic [CW-1:0] cmdCount = '0;
  logic [DW-1:0] wrData = '0;
  logic [DW-1:0] adIn = '0;
  logic locReady = 1'b0;
  logic trdy = 1'b0;
  logic stop = 1'b0;
  logic cmdReady, wordMoved, doneValid, doneStopped, frameN, irdyN, adOe;
  logic [DW-1:0] rdData, adOut;
  logic [CW-1:0] doneCount;
  logic [3:0] busCmd;

  int checks = 0;
  int errors = 0;
  int locPct = 100, trdyPct = 100, stopPct = 0;
  bit noise = 0;

  // behavioural reference
  int mPhase = 0;  // 0 idle 1 frame 2 address 3 turnaround 4 data
  bit mWrite = 0;
  logic [DW-1:0] mAddr = '0;
  int mRemain = 0, mMoved = 0, mDoneCnt = 0;
  bit mDone = 0, mDoneStop = 0;

  always #2.5 clk = ~clk;

  burstInit #(.DW(DW), .CW(CW)) i_burstInit (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdCount(cmdCount),
    .wrData(wrData), .locReady(locReady), .wordMoved(wordMoved),
    .rdData(rdData), .doneValid(doneValid), .doneCount(doneCount),
    .doneStopped(doneStopped), .frameN(frameN), .irdyN(irdyN),
    .trdyN(~trdy), .stopN(~stop), .busCmd(busCmd), .adOut(adOut),
    .adOe(adOe), .adIn(adIn)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0; mDone = 0; mDoneStop = 0; mDoneCnt = 0;
    end else begin
      mDone = 0;
      case (mPhase)
        0: if (cmdValid) begin
             mWrite = cmdWrite; mAddr = cmdAddr;
             mRemain = (cmdCount == 0) ? 1 : int'(cmdCount);  // R8
             mMoved = 0; mPhase = 1;
           end
        1: mPhase = 2;
        2: mPhase = mWrite ? 4 : 3;
        3: mPhase = 4;
        default: begin
          bit mv, fin;
          mv = locReady && trdy;
          fin = (mv && mRemain == 1) || stop;
          if (mv) begin mRemain--; mMoved++; end
          if (fin) begin
            mDone = 1; mDoneCnt = mMoved; mDoneStop = stop; mPhase = 0;
          end
        end
      endcase
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    #1;
    chk("R1 cmdReady", cmdReady, mPhase == 0);
    chk("R5 frame", !frameN, (mPhase inside {1, 2, 3}) || (mPhase == 4 && mRemain > 1));
    chk("R3 adOe", adOe, mPhase == 2 || (mPhase == 4 && mWrite));
    chk("R4 irdy", !irdyN, mPhase == 4 && locReady);
    chk("R4 wordMoved", wordMoved, mPhase == 4 && locReady && trdy);
    chk("R2 busCmd", busCmd, mPhase == 2 ? (mWrite ? 4'b0111 : 4'b0110) : 4'b0000);
    if (mPhase == 2) chk("R2 address", adOut, mAddr);
    if (mPhase == 4 && mWrite) chk("R3 write data", adOut, wrData);
    if (mPhase == 4 && !mWrite) chk("R4 read data", rdData, adIn);
    chk("R7 doneValid", doneValid, mDone);
    if (mDone) begin
      chk("R7 doneCount", doneCount, mDoneCnt);
      chk("R6 doneStopped", doneStopped, mDoneStop);
    end
  end

  task automatic step();
    @(negedge clk);
    locReady = ($urandom % 100) < locPct;
    trdy     = ($urandom % 100) < trdyPct;
    stop     = ($urandom % 100) < stopPct;
    wrData   = 32'hA500_0000 + mMoved;
    adIn     = 32'h5A00_0000 + mMoved + ($urandom % 16) * 32'h100;
    cmdValid = noise && (mPhase inside {1, 2, 3});
    cmdAddr  = $urandom;
    cmdWrite = $urandom % 2;
  endtask

  task automatic runTxn(input bit w, input logic [DW-1:0] a, input logic [CW-1:0] n,
                        output int gotCnt, output bit gotStop);
    @(negedge clk);
    cmdValid = 1; cmdWrite = w; cmdAddr = a; cmdCount = n;
    locReady = 0; trdy = 0; stop = 0;
    do begin
      step();
      #2;
    end while (!doneValid);
    gotCnt = doneCount;
    gotStop = doneStopped;
  endtask

  initial begin
    int c;
    bit s;
    repeat (3) @(negedge clk);
    #1;
    // R9 reset state
    chk("R9 reset cmdReady", cmdReady, 1);
    chk("R9 reset frameN", frameN, 1);
    chk("R9 reset irdyN", irdyN, 1);
    chk("R9 reset adOe", adOe, 0);
    chk("R9 reset doneValid", doneValid, 0);
    @(negedge clk); rstN = 1;

    // write, both sides always ready
    runTxn(1, 32'h0000_1000, 4, c, s);
    chk("R7 full write count", c, 4); chk("R7 no stop", s, 0);
    // read with waits on both sides, noise on command port while busy (R1)
    locPct = 60; trdyPct = 50; noise = 1;
    runTxn(0, 32'h0000_2000, 5, c, s);
    chk("R7 read count", c, 5);
    noise = 0;
    // single-word bursts
    runTxn(1, 32'h0000_3000, 1, c, s);
    chk("R5 single write", c, 1);
    runTxn(0, 32'h0000_3100, 1, c, s);
    chk("R5 single read", c, 1);
    // R8 zero count
    locPct = 100; trdyPct = 100;
    runTxn(1, 32'h0000_4000, 0, c, s);
    chk("R8 zero count", c, 1);
    // R6 stop with no target ready: nothing moves
    trdyPct = 0; stopPct = 100;
    runTxn(0, 32'h0000_5000, 6, c, s);
    chk("R6 stop no word", c, 0); chk("R6 stop flag", s, 1);
    // R6 stop together with both readies: one word counts
    trdyPct = 100;
    runTxn(1, 32'h0000_6000, 6, c, s);
    chk("R6 stop with word", c, 1); chk("R6 stop flag write", s, 1);
    // random mix
    locPct = 70; trdyPct = 70; stopPct = 8; noise = 1;
    for (int i = 0; i < 60; i++) begin
      runTxn(i % 2, 32'h1000_0000 + i * 64, CW'($urandom % 9), c, s);
    end
    noise = 0; stopPct = 0;
    repeat (4) step();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule